// File: doc/BRIEF.md
# Power-Up Self-Test Sequencer

This block steps through a numbered list of self-test engines after reset, one engine at a time. Before an engine is started, its 1-based number is put on a 4-bit indicator code and left there for a short display interval. The engine is then fired with a single-cycle start pulse, and the sequencer waits for its done strobe. If done does not arrive within a timeout window, the test is counted as a failure. A passing result lights the green indicator. A failing result lights the red indicator, and the red indicator stays lit while the fault is being handled.

Failure handling is driven by two push buttons. If neither button is pressed, the failing test is rerun again and again with its code held on the display, until a rerun passes. The skip button drops the fault and moves on to the next test. The loop button switches to continuous reruns of the current test that ignore its results; only a later skip press ends them. A burn-in input, sampled when the sequence begins, limits the sequence to tests 1 to BURN_LAST and repeats that range without end. Button presses are synchronized and edge-detected. A press made while no fault is showing is discarded.

Top module: `selftest_seq`

## Requirements
- R1: While reset is high, test_start, code_led, green_led, red_led and seq_done are all 0.
- R2: With burn_in low and every test passing, the tests start exactly once each, in the order 1 to NUM_TESTS. After the last one, seq_done goes high and stays high, and no further start pulse appears.
- R3: Test n is started by bit n-1 of test_start. code_led equals n in the cycle of that start pulse and holds n until the test's result is taken.
- R4: A passing result sets green_led. green_led is 0 in the cycle in which the next start pulse is issued.
- R5: A failing result sets red_led. red_led rises only at the end of a test wait, and code_led keeps the failing test's number.
- R6: If no button is pressed after a failure, the same test is rerun. The first rerun that passes clears red_led, and the sequence moves on to the next test.
- R7: A skip press during a fault clears red_led, and the next test is the one that runs, whether or not the failing test would pass.
- R8: A loop press during a fault puts the sequencer into continuous mode. In this mode the test is rerun even after passing results and red_led stays lit. A later skip press leaves continuous mode and moves on to the next test.
- R9: test_start is zero or one-hot, and every start pulse lasts exactly one cycle.
- R10: If the started test does not raise its done bit within TIMEOUT_CYCLES+1 cycles of waiting, the test is counted as failed, and the next start comes more than TIMEOUT_CYCLES cycles after the previous one.
- R11: A button held high for several cycles counts as a single press. One skip press moves the sequence on by exactly one test, and a next test that also fails is then rerun.
- R12: If burn_in is high when the sequence begins, the tests run in the order 1 to BURN_LAST over and over, and seq_done stays low.
- R13: Skip or loop presses made while red_led is low have no effect, and none of them is stored for a later fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| burn_in | input | 1 | Selects endless repetition of tests 1 to BURN_LAST; sampled when the sequence begins |
| btn_skip | input | 1 | Asynchronous skip button, high while pressed |
| btn_loop | input | 1 | Asynchronous continuous-loop button, high while pressed |
| test_done | input | NUM_TESTS | Done strobe from each test engine; bit n-1 belongs to test n |
| test_pass | input | NUM_TESTS | Pass flag of each engine, valid together with its done bit |
| test_start | output | NUM_TESTS | One-cycle start pulse; bit n-1 starts test n |
| code_led | output | CODE_W | Number of the current test (0 after reset) |
| green_led | output | 1 | Last result passed |
| red_led | output | 1 | Fault present |
| seq_done | output | 1 | Sequence completed (normal mode only) |

## Verification
The checker checks on every cycle that start pulses are one-hot and last a single cycle, that the displayed code stays stable and in range while a test is awaited, that the red indicator rises only at the end of a wait, that a wait never runs past the timeout window, and that completion stays latched with no further starts. The bench scenarios are the only place that shows the order of tests, the decisions between rerun, skip and continuous mode, the single-event behaviour of held buttons, the discarding of presses made while no fault shows, and the wrap-around in burn-in mode.

// File: rtl/stm_pkg.sv
package stm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHOW,
    ST_START,
    ST_WAIT,
    ST_HOLD,
    ST_FINISH
  } seq_state_t;
endpackage

// File: rtl/stm_btn_sync.sv
module stm_btn_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] btn,
  output logic [N-1:0] press
);
  // One synchronizer chain per button, followed by one register for edge detection.
  for (genvar i = 0; i < N; i++) begin : g_btn
    logic [STAGES:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[STAGES-1:0], btn[i]};
    end
    assign press[i] = sh[STAGES-1] & ~sh[STAGES];
  end
endmodule

// File: rtl/stm_timer.sv
module stm_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt;
  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= val;
    else if (cnt != '0)   cnt <= cnt - W'(1);
  end
  assign zero = (cnt == '0);
endmodule

// File: rtl/stm_core.sv
module stm_core
  import stm_pkg::*;
#(
  parameter int NUM_TESTS      = 8,
  parameter int BURN_LAST      = 6,
  parameter int CODE_W         = 4,
  parameter int HOLD_CYCLES    = 8,
  parameter int TIMEOUT_CYCLES = 1024,
  parameter int TMR_W          = 11
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 burn_in,
  input  logic                 ev_skip,
  input  logic                 ev_loop,
  input  logic [NUM_TESTS-1:0] test_done,
  input  logic [NUM_TESTS-1:0] test_pass,
  input  logic                 tmr_zero,
  output logic                 tmr_load,
  output logic [TMR_W-1:0]     tmr_val,
  output logic [NUM_TESTS-1:0] test_start,
  output logic [CODE_W-1:0]    code,
  output logic                 green,
  output logic                 red,
  output logic                 finished,
  output logic                 busy
);
  seq_state_t          state;
  logic [CODE_W-1:0]   idx;
  logic                burn, cont, skip_req, loop_req, last_pass;
  logic                sel_done, sel_pass, wait_end, wait_res, adv;
  logic [CODE_W-1:0]   last_idx;

  always_comb begin
    sel_done = 1'b0;
    sel_pass = 1'b0;
    for (int i = 0; i < NUM_TESTS; i++) begin
      if (idx == CODE_W'(i + 1)) begin
        sel_done = test_done[i];
        sel_pass = test_pass[i];
      end
    end
  end

  assign wait_end = sel_done | tmr_zero;
  assign wait_res = sel_done & sel_pass;
  assign adv      = (red & skip_req) | (last_pass & ~cont & ~loop_req);
  assign last_idx = burn ? CODE_W'(BURN_LAST) : CODE_W'(NUM_TESTS);

  assign tmr_load = (state == ST_IDLE) || (state == ST_START) ||
                    (state == ST_WAIT && wait_end) ||
                    (state == ST_HOLD && tmr_zero);
  assign tmr_val  = (state == ST_START) ? TMR_W'(TIMEOUT_CYCLES) : TMR_W'(HOLD_CYCLES);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      idx        <= '0;
      burn       <= 1'b0;
      cont       <= 1'b0;
      skip_req   <= 1'b0;
      loop_req   <= 1'b0;
      last_pass  <= 1'b0;
      test_start <= '0;
      green      <= 1'b0;
      red        <= 1'b0;
      finished   <= 1'b0;
    end else begin
      test_start <= '0;
      if (ev_skip && red) skip_req <= 1'b1;
      if (ev_loop && red) loop_req <= 1'b1;
      case (state)
        ST_IDLE: begin
          burn  <= burn_in;
          idx   <= CODE_W'(1);
          state <= ST_SHOW;
        end
        ST_SHOW: begin
          if (tmr_zero) state <= ST_START;
        end
        ST_START: begin
          for (int i = 0; i < NUM_TESTS; i++)
            test_start[i] <= (idx == CODE_W'(i + 1));
          green <= 1'b0;
          state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (wait_end) begin
            green     <= wait_res;
            last_pass <= wait_res;
            if (!wait_res) red <= 1'b1;
            state <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (tmr_zero) begin
            if (loop_req) begin
              cont     <= 1'b1;
              loop_req <= 1'b0;
            end
            if (adv) begin
              red      <= 1'b0;
              cont     <= 1'b0;
              skip_req <= 1'b0;
              loop_req <= 1'b0;
              if (idx == last_idx) begin
                if (burn) begin
                  idx   <= CODE_W'(1);
                  state <= ST_SHOW;
                end else begin
                  finished <= 1'b1;
                  state    <= ST_FINISH;
                end
              end else begin
                idx   <= idx + CODE_W'(1);
                state <= ST_SHOW;
              end
            end else begin
              state <= ST_SHOW;
            end
          end
        end
        default: state <= ST_FINISH;
      endcase
    end
  end

  assign code = idx;
  assign busy = (state == ST_WAIT);
endmodule

// File: rtl/selftest_seq.sv
module selftest_seq #(
  parameter int NUM_TESTS      = 8,
  parameter int BURN_LAST      = 6,
  parameter int CODE_W         = 4,
  parameter int HOLD_CYCLES    = 8,
  parameter int TIMEOUT_CYCLES = 1024,
  parameter int SYNC_STAGES    = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 burn_in,
  input  logic                 btn_skip,
  input  logic                 btn_loop,
  input  logic [NUM_TESTS-1:0] test_done,
  input  logic [NUM_TESTS-1:0] test_pass,
  output logic [NUM_TESTS-1:0] test_start,
  output logic [CODE_W-1:0]    code_led,
  output logic                 green_led,
  output logic                 red_led,
  output logic                 seq_done
);
  localparam int TMAX  = (TIMEOUT_CYCLES > HOLD_CYCLES) ? TIMEOUT_CYCLES : HOLD_CYCLES;
  localparam int TMR_W = $clog2(TMAX + 1);

  logic [1:0]       press;
  logic             tmr_load, tmr_zero, core_busy;
  logic [TMR_W-1:0] tmr_val;

  stm_btn_sync #(.N(2), .STAGES(SYNC_STAGES)) u_btn (
    .clk(clk), .rst(rst), .btn({btn_loop, btn_skip}), .press(press)
  );

  stm_timer #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .val(tmr_val), .zero(tmr_zero)
  );

  stm_core #(
    .NUM_TESTS(NUM_TESTS), .BURN_LAST(BURN_LAST), .CODE_W(CODE_W),
    .HOLD_CYCLES(HOLD_CYCLES), .TIMEOUT_CYCLES(TIMEOUT_CYCLES), .TMR_W(TMR_W)
  ) u_core (
    .clk(clk), .rst(rst), .burn_in(burn_in),
    .ev_skip(press[0]), .ev_loop(press[1]),
    .test_done(test_done), .test_pass(test_pass),
    .tmr_zero(tmr_zero), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .test_start(test_start), .code(code_led),
    .green(green_led), .red(red_led), .finished(seq_done), .busy(core_busy)
  );
endmodule

// File: rtl/stm_checker.sv
module stm_checker #(
  parameter int NUM_TESTS      = 8,
  parameter int CODE_W         = 4,
  parameter int TIMEOUT_CYCLES = 1024
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_TESTS-1:0] test_start,
  input logic [CODE_W-1:0]    code_led,
  input logic                 red_led,
  input logic                 seq_done,
  input logic                 busy
);
  localparam int WC_W = $clog2(TIMEOUT_CYCLES + 4);
  logic [WC_W-1:0] wcnt;

  always_ff @(posedge clk) begin
    if (rst || !busy) wcnt <= '0;
    else              wcnt <= wcnt + WC_W'(1);
  end

  assert_start_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(test_start));

  assert_start_single_R9: assert property (@(posedge clk) disable iff (rst)
    (test_start != '0) |=> (test_start == '0));

  assert_code_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(code_led));

  assert_code_range_R3: assert property (@(posedge clk) disable iff (rst)
    (test_start != '0) |-> (code_led != '0 && code_led <= CODE_W'(NUM_TESTS)));

  assert_red_rise_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(red_led) |-> $past(busy));

  assert_finish_hold_R2: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> (seq_done && test_start == '0));

  assert_wait_bound_R10: assert property (@(posedge clk) disable iff (rst)
    wcnt <= WC_W'(TIMEOUT_CYCLES + 1));
endmodule

bind selftest_seq stm_checker #(
  .NUM_TESTS(NUM_TESTS), .CODE_W(CODE_W), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .test_start(test_start), .code_led(code_led),
  .red_led(red_led), .seq_done(seq_done), .busy(core_busy)
);

// File: tb/tb_selftest_seq.sv
`timescale 1ns/1ps
module tb_selftest_seq;
  localparam int NT = 8;
  localparam int BL = 6;
  localparam int TO = 50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic burn_in = 1'b0;
  logic btn_skip = 1'b0;
  logic btn_loop = 1'b0;
  logic [NT-1:0] test_done = '0;
  logic [NT-1:0] test_pass = '0;
  logic [NT-1:0] test_start;
  logic [3:0]    code_led;
  logic          green_led, red_led, seq_done;

  selftest_seq #(.NUM_TESTS(NT), .BURN_LAST(BL), .CODE_W(4), .HOLD_CYCLES(4),
                 .TIMEOUT_CYCLES(TO), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .burn_in(burn_in), .btn_skip(btn_skip), .btn_loop(btn_loop),
    .test_done(test_done), .test_pass(test_pass), .test_start(test_start),
    .code_led(code_led), .green_led(green_led), .red_led(red_led), .seq_done(seq_done)
  );

  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic [NT-1:0] pass_cfg;
  logic [NT-1:0] hang_cfg;
  int log_num [0:63];
  int log_cyc [0:63];
  logic log_green [0:63];
  int log_n = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Engine model and start monitor on the falling edge.
  initial begin
    bit ebusy = 0;
    int ecnt = 0;
    int eidx = 0;
    forever begin
      @(negedge clk);
      cyc++;
      test_done = '0;
      test_pass = '0;
      if (rst) begin
        ebusy = 0;
      end else begin
        if (ebusy) begin
          if (ecnt == 0) begin
            if (!hang_cfg[eidx]) begin
              test_done[eidx] = 1'b1;
              test_pass[eidx] = pass_cfg[eidx];
            end
            ebusy = 0;
          end else ecnt--;
        end
        if (test_start != '0) begin
          for (int i = 0; i < NT; i++) if (test_start[i]) eidx = i;
          ebusy = 1;
          ecnt = 2;
          check(code_led == 4'(eidx + 1), "R3 code at start", code_led, eidx + 1);
          if (log_n < 64) begin
            log_num[log_n] = eidx + 1;
            log_cyc[log_n] = cyc;
            log_green[log_n] = green_led;
            log_n++;
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic do_reset(input bit burn);
    rst = 1'b1;
    burn_in = burn;
    pass_cfg = '1;
    hang_cfg = '0;
    repeat (3) @(negedge clk);
    log_n = 0;
    rst = 1'b0;
  endtask

  task automatic wait_starts(input int n);
    int g = 0;
    while (log_n < n && g < 5000) begin
      @(negedge clk);
      g++;
    end
    check(log_n >= n, "wait for start pulses", log_n, n);
  endtask

  task automatic press(input bit which_loop);
    if (which_loop) btn_loop = 1'b1; else btn_skip = 1'b1;
    repeat (6) @(negedge clk);
    btn_loop = 1'b0;
    btn_skip = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(test_start == '0 && code_led == 0 && !green_led && !red_led && !seq_done,
          "R1 reset state", {test_start, code_led, green_led, red_led, seq_done}, 0);
  endtask

  task automatic t_normal;
    bit ok = 1;
    bit gok = 1;
    int g = 0;
    do_reset(0);
    while (!seq_done && g < 3000) begin @(negedge clk); g++; end
    check(seq_done, "R2 finished", seq_done, 1);
    check(log_n == NT, "R2 start count", log_n, NT);
    for (int k = 0; k < NT; k++) if (log_num[k] != k + 1) ok = 0;
    check(ok, "R2 order", ok, 1);
    for (int k = 1; k < log_n; k++) if (log_green[k]) gok = 0;
    check(gok, "R4 green low at next start", gok, 1);
    check(green_led && !red_led, "R4 green after pass", {green_led, red_led}, 2);
    repeat (30) @(negedge clk);
    check(log_n == NT && seq_done, "R2 no start after finish", log_n, NT);
  endtask

  task automatic t_default_loop;
    do_reset(0);
    pass_cfg[1] = 1'b0;
    wait_starts(4);
    check(log_num[1] == 2 && log_num[2] == 2 && log_num[3] == 2, "R6 rerun failing test",
          log_num[3], 2);
    check(red_led, "R5 red on fail", red_led, 1);
    check(code_led == 2, "R5 code held", code_led, 2);
    pass_cfg[1] = 1'b1;
    wait_starts(6);
    check(log_num[4] == 3 && log_num[5] == 4, "R6 advance after passing rerun", log_num[4], 3);
    check(!red_led, "R6 red cleared", red_led, 0);
  endtask

  task automatic t_skip;
    do_reset(0);
    pass_cfg[2] = 1'b0;
    pass_cfg[3] = 1'b0;
    wait_starts(4);
    press(0);
    wait_starts(7);
    check(log_num[4] == 4, "R7 skip to next test", log_num[4], 4);
    check(log_num[5] == 4 && log_num[6] == 4, "R11 one press one skip", log_num[6], 4);
    check(red_led, "R11 new fault lit", red_led, 1);
  endtask

  task automatic t_continuous;
    do_reset(0);
    pass_cfg[1] = 1'b0;
    wait_starts(3);
    press(1);
    wait_starts(5);
    pass_cfg[1] = 1'b1;
    wait_starts(8);
    check(log_num[5] == 2 && log_num[6] == 2 && log_num[7] == 2,
          "R8 reruns despite pass", log_num[7], 2);
    check(red_led, "R8 red stays", red_led, 1);
    press(0);
    wait_starts(9);
    check(log_num[log_n - 1] == 3, "R8 skip leaves continuous", log_num[log_n - 1], 3);
    check(!red_led, "R8 red cleared by skip", red_led, 0);
  endtask

  task automatic t_timeout;
    do_reset(0);
    hang_cfg[0] = 1'b1;
    wait_starts(2);
    check(log_num[0] == 1 && log_num[1] == 1, "R10 timeout reruns", log_num[1], 1);
    check(log_cyc[1] - log_cyc[0] > TO, "R10 wait length", log_cyc[1] - log_cyc[0], TO);
    check(red_led, "R10 red after timeout", red_led, 1);
  endtask

  task automatic t_burn;
    bit ok = 1;
    do_reset(1);
    wait_starts(14);
    for (int k = 0; k < 14; k++) if (log_num[k] != (k % BL) + 1) ok = 0;
    check(ok, "R12 burn-in order", ok, 1);
    check(!seq_done, "R12 never finishes", seq_done, 0);
  endtask

  task automatic t_ignored;
    bit ok = 1;
    int expv [0:6] = '{1, 2, 3, 4, 5, 5, 5};
    do_reset(0);
    pass_cfg[4] = 1'b0;
    wait_starts(2);
    press(0);
    press(1);
    wait_starts(7);
    for (int k = 0; k < 7; k++) if (log_num[k] != expv[k]) ok = 0;
    check(ok, "R13 presses without fault ignored", log_num[6], 5);
  endtask

  initial begin
    pass_cfg = '1;
    hang_cfg = '0;
    t_reset();
    t_normal();
    t_default_loop();
    t_skip();
    t_continuous();
    t_timeout();
    t_burn();
    t_ignored();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule